// File: doc/BRIEF.md
# Four-Tap Mismatch-Count Correlator

This block slides a four-symbol window over an incoming symbol stream and reports, for every accepted symbol, how many window positions differ from a set of four reference symbols. The newest symbol is paired with reference slot 0, the one before it with slot 1, and so on up to slot 3 for the oldest. A count of 0 means the last four symbols match the reference pattern exactly. This makes the block a pattern or sync-word detector whose output also shows how close a near-miss was.

Symbols move along a chain of comparator cells. Each cell holds one delayed symbol and raises a single mismatch bit. The four bits are reduced by a two-level tree of three adders, with a register after each level. No combinational path holds more than one comparator and one adder. The block accepts one symbol per clock. The result comes out a fixed number of cycles later together with its own valid strobe. The reference symbols come from a configuration input, which is expected to stay constant while a stream is running.

Top module: `mismatch_corr`

## Requirements
- R1: For each accepted symbol x(t), the reported count equals the number of slots k in 0..3 for which x(t-k) differs from reference slot k. Here x(t-k) is the k-th previously accepted symbol, and reference slot k sits at bits [k*SYM_W +: SYM_W] of `ref_syms_i`.
- R2: The count is 3 bits wide and never exceeds 4. A window equal to the reference gives 0, and a window that differs in every slot gives 4.
- R3: `out_valid_o` rises exactly LATENCY = 3 + EXTRA_STAGES clock edges after the edge that accepts a symbol. The edge that accepts the symbol counts as the first. There is one valid output per accepted symbol.
- R4: A cycle with `in_valid_i` low does not shift the window and produces no output. While `out_valid_o` is low, `out_count_o` keeps its last value.
- R5: A synchronous active-low reset clears `out_valid_o`, `out_count_o` and every window and pipeline register. After reset the window holds all-zero symbols until four new symbols arrive.
- R6: Symbols may be presented on every clock with no gaps, and each one yields a result.
- R7: The newest symbol is compared with slot 0 and the oldest with slot 3. Feeding slot 3, 2, 1, 0 in that order gives a count of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Symbol strobe; the symbol is accepted at the edge where this is high |
| in_sym_i | input | SYM_W | Incoming symbol |
| ref_syms_i | input | 4*SYM_W | Reference symbols, slot k at bits [k*SYM_W +: SYM_W] |
| out_valid_o | output | 1 | Result strobe |
| out_count_o | output | 3 | Number of mismatching slots, 0 to 4 |

## Verification
A short hand-computed stream with distinct reference values first climbs to an exact match, with gaps in the strobe. It then feeds the reference slots in rotated orders. Any swap of tap order, a skipped shift or a stalled gap shows up as a wrong count. A long pseudo-random stream draws most symbols from the reference set and regularly forces the full matching sequence, so every count from 0 to 4 appears under back-to-back and gapped input. A mid-stream reset then proves that the history restarts from zero symbols and that the output and strobe clear.

// File: rtl/corr_pkg.sv
// Package: shared constants for the mismatch-count correlator.
// Assumes a fixed tap count of four, reduced by a two-level adder tree.
package corr_pkg;
    localparam int NTAP   = 4;
    localparam int PAIR_W = 2;   // width of a sum of two mismatch bits
    localparam int CNT_W  = 3;   // width of the full count (0..4)
    localparam int TREE_STAGES = 3; // input register + two adder levels
endpackage

// File: rtl/corr_tap.sv
// Comparator cell: holds one delayed symbol of the window and flags
// whether it differs from its reference slot. The held symbol also
// feeds the next cell. Assumes ref_i is stable while the stream runs.
module corr_tap #(
    parameter int SYM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SYM_W-1:0] sym_i,
    input  logic [SYM_W-1:0] ref_i,
    output logic [SYM_W-1:0] sym_o,
    output logic             miss_o
);
    logic [SYM_W-1:0] sym_q;

    // Shift register cell: load the incoming symbol on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    sym_q <= '0;
        else if (en_i) sym_q <= sym_i;
    end

    // Comparator: one mismatch bit per cell.
    always_comb begin
        miss_o = (sym_q != ref_i);
        sym_o  = sym_q;
    end

    // Window must not move on idle cycles.
    assert_tap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(sym_q));
endmodule

// File: rtl/corr_add_stage.sv
// Registered adder: sums two operands and captures the result only when
// the enable (the stage's incoming valid) is high, else holds.
module corr_add_stage #(
    parameter int IN_W  = 1,
    parameter int OUT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [IN_W-1:0]  a_i,
    input  logic [IN_W-1:0]  b_i,
    output logic [OUT_W-1:0] sum_o
);
    // Sum register: capture a + b on enable.
    always_ff @(posedge clk) begin
        if (!rst_n)    sum_o <= '0;
        else if (en_i) sum_o <= OUT_W'(a_i) + OUT_W'(b_i);
    end
endmodule

// File: rtl/corr_delay.sv
// Optional output delay line of STAGES (valid, data) pairs. Data loads
// only with a valid entry, so the last result stays visible while idle.
// With STAGES = 0 it is a plain wire.
module corr_delay #(
    parameter int W      = 3,
    parameter int STAGES = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] dat_i,
    output logic         vld_o,
    output logic [W-1:0] dat_o
);
    generate
        if (STAGES == 0) begin : g_wire
            always_comb begin
                vld_o = vld_i;
                dat_o = dat_i;
            end
        end else begin : g_regs
            logic         v_q [STAGES];
            logic [W-1:0] d_q [STAGES];
            for (genvar i = 0; i < STAGES; i++) begin : g_st
                logic         v_in;
                logic [W-1:0] d_in;
                if (i == 0) begin : g_first
                    assign v_in = vld_i;
                    assign d_in = dat_i;
                end else begin : g_next
                    assign v_in = v_q[i-1];
                    assign d_in = d_q[i-1];
                end
                // Delay stage: pass valid every cycle, data only when valid.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        v_q[i] <= 1'b0;
                        d_q[i] <= '0;
                    end else begin
                        v_q[i] <= v_in;
                        if (v_in) d_q[i] <= d_in;
                    end
                end
            end
            always_comb begin
                vld_o = v_q[STAGES-1];
                dat_o = d_q[STAGES-1];
            end
        end
    endgenerate
endmodule

// File: rtl/mismatch_corr.sv
// Top: four-tap sliding mismatch counter. A chain of comparator cells holds
// the window and a two-level registered adder tree reduces the mismatch
// bits, so each path has at most one comparator and one adder.
// Latency from accepting edge to output is 3 + EXTRA_STAGES edges.
// Assumes ref_syms_i is held constant during a stream.
module mismatch_corr #(
    parameter int SYM_W        = 8,
    parameter int EXTRA_STAGES = 0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid_i,
    input  logic [SYM_W-1:0]               in_sym_i,
    input  logic [corr_pkg::NTAP*SYM_W-1:0] ref_syms_i,
    output logic                           out_valid_o,
    output logic [corr_pkg::CNT_W-1:0]     out_count_o
);
    import corr_pkg::*;

    localparam int LATENCY = TREE_STAGES + EXTRA_STAGES;

    logic [SYM_W-1:0] chain [NTAP];
    logic [NTAP-1:0]  miss;

    // Comparator chain: cell k holds the k-th previous accepted symbol.
    generate
        for (genvar k = 0; k < NTAP; k++) begin : g_tap
            logic [SYM_W-1:0] tap_in;
            if (k == 0) begin : g_head
                assign tap_in = in_sym_i;
            end else begin : g_link
                assign tap_in = chain[k-1];
            end
            corr_tap #(.SYM_W(SYM_W)) tap_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .en_i   (in_valid_i),
                .sym_i  (tap_in),
                .ref_i  (ref_syms_i[k*SYM_W +: SYM_W]),
                .sym_o  (chain[k]),
                .miss_o (miss[k])
            );
        end
    endgenerate

    logic v_win, v_pair, v_sum;

    // Valid pipeline: follows the window, pair and sum registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_win  <= 1'b0;
            v_pair <= 1'b0;
            v_sum  <= 1'b0;
        end else begin
            v_win  <= in_valid_i;
            v_pair <= v_win;
            v_sum  <= v_pair;
        end
    end

    logic [PAIR_W-1:0] pair_lo, pair_hi;
    logic [CNT_W-1:0]  sum_q;

    // First adder level: comparator output plus one adder per path.
    corr_add_stage #(.IN_W(1), .OUT_W(PAIR_W)) add_lo_i (
        .clk(clk), .rst_n(rst_n), .en_i(v_win),
        .a_i(miss[0]), .b_i(miss[1]), .sum_o(pair_lo)
    );
    corr_add_stage #(.IN_W(1), .OUT_W(PAIR_W)) add_hi_i (
        .clk(clk), .rst_n(rst_n), .en_i(v_win),
        .a_i(miss[2]), .b_i(miss[3]), .sum_o(pair_hi)
    );
    // Second adder level: combine the two pair sums.
    corr_add_stage #(.IN_W(PAIR_W), .OUT_W(CNT_W)) add_top_i (
        .clk(clk), .rst_n(rst_n), .en_i(v_pair),
        .a_i(pair_lo), .b_i(pair_hi), .sum_o(sum_q)
    );

    corr_delay #(.W(CNT_W), .STAGES(EXTRA_STAGES)) out_dly_i (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (v_sum),
        .dat_i (sum_q),
        .vld_o (out_valid_o),
        .dat_o (out_count_o)
    );

    assert_pair_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        v_pair |-> (pair_lo <= 2 && pair_hi <= 2));

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> out_count_o <= 3'd4);

    assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |=> (out_valid_o || $stable(out_count_o)));

    assert_reset_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid_o && out_count_o == '0));

    initial begin
        assert (LATENCY >= TREE_STAGES)
            else $error("latency below tree depth");
    end
endmodule

// File: tb/mismatch_corr_tb_top.sv
module mismatch_corr_tb_top;
    localparam int SYM_W = 8;
    localparam int EXTRA = 0;
    localparam int LAT   = 3 + EXTRA;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid_i = 1'b0;
    logic [SYM_W-1:0]     in_sym_i = '0;
    logic [4*SYM_W-1:0]   ref_syms_i = '0;
    logic                 out_valid_o;
    logic [2:0]           out_count_o;

    always #2.5 clk = ~clk; // 200 MHz

    mismatch_corr #(.SYM_W(SYM_W), .EXTRA_STAGES(EXTRA)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_sym_i(in_sym_i),
        .ref_syms_i(ref_syms_i), .out_valid_o(out_valid_o), .out_count_o(out_count_o)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Reference model state.
    logic [SYM_W-1:0] hist [4];
    logic             pv [LAT];
    logic [2:0]       pc [LAT];
    logic [2:0]       last_cnt;

    // Table: {valid, expected count, symbol}; refs slot0..3 = 11,22,33,44 (R7).
    localparam logic [11:0] VEC [0:15] = '{
        {1'b1,3'd4,8'h44}, {1'b1,3'd4,8'h33}, {1'b1,3'd4,8'h22}, {1'b1,3'd0,8'h11},
        {1'b0,3'd0,8'h99}, {1'b1,3'd3,8'h11}, {1'b1,3'd4,8'h22}, {1'b1,3'd3,8'h33},
        {1'b1,3'd4,8'h44}, {1'b1,3'd2,8'h11}, {1'b1,3'd4,8'h22}, {1'b0,3'd0,8'h11},
        {1'b1,3'd2,8'h44}, {1'b1,3'd4,8'h33}, {1'b1,3'd4,8'h22}, {1'b1,3'd0,8'h11}
    };

    function automatic logic [2:0] model_count(input logic [SYM_W-1:0] h [4],
                                               input logic [4*SYM_W-1:0] r);
        logic [2:0] c = 3'd0;
        for (int k = 0; k < 4; k++)
            if (h[k] != r[k*SYM_W +: SYM_W]) c = c + 3'd1;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 4; k++) hist[k] = '0;
        for (int i = 0; i < LAT; i++) begin pv[i] = 1'b0; pc[i] = '0; end
        last_cnt = '0;
    endtask

    // One clock: drive at negedge, update model at the edge, check after.
    // use_tab: take expected count from the table instead of the model.
    task automatic step(input logic v, input logic [SYM_W-1:0] s,
                        input bit use_tab, input logic [2:0] tab_exp);
        logic [2:0] e;
        in_valid_i = v;
        in_sym_i   = s;
        @(posedge clk);
        if (!rst_n) begin
            model_clear();
        end else begin
            for (int i = LAT-1; i > 0; i--) begin pv[i] = pv[i-1]; pc[i] = pc[i-1]; end
            pv[0] = v;
            if (v) begin
                for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
                hist[0] = s;
                e = use_tab ? tab_exp : model_count(hist, ref_syms_i);
                pc[0] = e;
            end
        end
        @(negedge clk);
        if (rst_n) begin
            check(out_valid_o == pv[LAT-1], "R3/R6 valid timing", out_valid_o, pv[LAT-1]);
            if (pv[LAT-1]) begin
                check(out_count_o == pc[LAT-1], use_tab ? "R1/R7 count" : "R1 count",
                      out_count_o, pc[LAT-1]);
                check(out_count_o <= 3'd4, "R2 range", out_count_o, 4);
                last_cnt = pc[LAT-1];
            end else begin
                check(out_count_o == last_cnt, "R4 hold", out_count_o, last_cnt);
            end
        end
    endtask

    initial begin : main
        logic [31:0] lcg;
        logic [SYM_W-1:0] s;
        model_clear();
        ref_syms_i = {8'h44, 8'h33, 8'h22, 8'h11};
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid_o == 1'b0, "R5 reset valid", out_valid_o, 0);
        check(out_count_o == 3'd0, "R5 reset count", out_count_o, 0);
        rst_n = 1'b1;

        // Table walk, then flush.
        for (int i = 0; i < 16; i++)
            step(VEC[i][11], VEC[i][7:0], 1'b1, VEC[i][10:8]);
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 8'hEE, 1'b0, 3'd0);

        // Random stream with forced exact matches (R2, R6, R7).
        ref_syms_i = {8'hA5, 8'h3C, 8'h5A, 8'hC3};
        lcg = 32'h1234_5678;
        for (int n = 0; n < 600; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            if (n % 40 < 4) begin
                step(1'b1, ref_syms_i[(3 - (n % 40))*SYM_W +: SYM_W], 1'b0, 3'd0);
            end else begin
                s = lcg[26] ? lcg[15:8] : ref_syms_i[lcg[13:12]*SYM_W +: SYM_W];
                step(lcg[31:30] != 2'b00, s, 1'b0, 3'd0);
            end
        end

        // Mid-stream reset: output and window clear (R5).
        step(1'b1, 8'h11, 1'b0, 3'd0);
        rst_n = 1'b0;
        step(1'b1, 8'h22, 1'b0, 3'd0);
        step(1'b1, 8'h22, 1'b0, 3'd0);
        check(out_valid_o == 1'b0, "R5 valid after reset", out_valid_o, 0);
        check(out_count_o == 3'd0, "R5 count after reset", out_count_o, 0);
        rst_n = 1'b1;
        // Only slot 0 nonzero: one symbol 07 leaves zero history -> count 0 (R5).
        ref_syms_i = {8'h00, 8'h00, 8'h00, 8'h07};
        step(1'b1, 8'h07, 1'b0, 3'd0);
        for (int i = 0; i < LAT + 1; i++) step(1'b0, 8'h00, 1'b0, 3'd0);
        check(last_cnt == 3'd0 && out_count_o == 3'd0, "R5 zero history",
              out_count_o, 0);
        // Idle input must not shift the window (R4): 07 then gap then 00 -> hist 00,07.
        ref_syms_i = {8'h00, 8'h00, 8'h07, 8'h00};
        step(1'b1, 8'h00, 1'b0, 3'd0);
        for (int i = 0; i < LAT + 1; i++) step(1'b0, 8'h00, 1'b0, 3'd0);
        check(out_count_o == 3'd0, "R4 gap no shift", out_count_o, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule